// File: doc/BRIEF.md
# Video Input Timing Front-End

This block sits between a video source and the converters of a video output path. It receives three 10-bit pixel channels, dedicated horizontal and vertical sync inputs, and one multipurpose input pin. That pin is used as a field indicator, as a data-enable, or is ignored, depending on a few static control bits. When the pin acts as a data-enable, each channel is replaced by its blanking code outside the active window. The blanking code depends on the colour space: in RGB, every channel blanks at the bottom code. In the luma/colour-difference space, luma blanks at the bottom and both colour-difference channels blank at mid-scale.

When the sync inputs are dedicated but no separate field signal is available, a small state machine measures the horizontal period. It recovers the field parity from where the vertical sync rising edge falls within the line. The block also counts horizontal sync pulses between frame starts, and it holds the last complete count for readback as an upper and a lower part. Pixel data and the three sync outputs all leave through one register stage, and each sync output has its own polarity bit.

The mode decoder produces one of four modes:
- `PM_FIELD_PIN`: the pin is taken as the field ID.
- `PM_DATA_EN`: the pin gates the pixels.
- `PM_FIELD_DERIVED`: the pin is ignored and the field is recovered.
- `PM_EMBEDDED`: the dedicated sync path is switched off.

The field state machine has three states:
- `FD_NO_SYNC` moves to `FD_MEASURE` on the first HS rise (transition "acquire").
- `FD_MEASURE` moves to `FD_LOCKED` on the next HS rise (transition "lock").
- `FD_MEASURE` and `FD_LOCKED` return to `FD_NO_SYNC` when the line position counter reaches its limit without an HS rise (transition "lose").

Top module: `vid_timing_front`

## Requirements
- R1: While reset is high, and one clock after it, the pixel outputs carry the blanking codes for the current colour space. Each sync output sits at its inactive level, and the line total reads 0.
- R2: With `cfg_pin_is_de`=0, `fid_out` follows the multipurpose pin, after polarity is applied, one clock later. Pixels pass unchanged.
- R3: With `cfg_pin_is_de`=1 and `cfg_pc_graphics`=1, a channel passes its input when the pin is 1 and outputs its blanking code when the pin is 0. The field output is then at its inactive level.
- R4: Blanking codes depend on `cfg_rgb_space`. When it is 1, all three channels use 64. When it is 0, channel Y/G uses 64 and channels Pb/B and Pr/R use 512.
- R5: With `cfg_pin_is_de`=1 and `cfg_pc_graphics`=0, the pin is ignored. After two or more HS rises, a VS rise sets the field to 1 if the position since the last HS rise lies between 1/4 and 3/4 of the measured line length. Otherwise it sets the field to 0.
- R6: Each VS rise is a frame start. At a frame start, the count of HS rises since the previous frame start is stored. It is read as `line_total_hi` (bits 10:8) and `line_total_lo` (bits 7:0), starting on the clock after that rise.
- R7: An HS rise in the same cycle as a frame start belongs to the new frame. It is not in the stored count. When both inputs rise together in derived mode, the field is 0.
- R8: The running line count saturates at 2047. A frame start after more than 2047 HS rises stores 2047.
- R9: `cfg_hs_pos`=1 and `cfg_fid_pos`=1 give active-high HS and field outputs, and 0 inverts them. `cfg_vs_neg`=1 gives an active-low VS output, and 0 gives active-high.
- R10: With `cfg_sync_embedded`=1, the dedicated HS, VS and pin are ignored. Sync outputs stay inactive, the line total does not change, and pixels pass unchanged.
- R11: Pixel outputs and sync outputs each have exactly one clock of latency, so that sync and data stay aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pin_is_de | input | 1 | 0: the multipurpose pin is the field ID; 1: data-enable or ignored, depending on mode |
| cfg_pc_graphics | input | 1 | 1: PC graphics timing; 0: SD/HD video timing |
| cfg_rgb_space | input | 1 | 1: RGB blanking; 0: luma/colour-difference blanking |
| cfg_sync_embedded | input | 1 | 1: disable the dedicated sync inputs |
| cfg_vs_neg | input | 1 | VS output polarity, 1 = active low |
| cfg_hs_pos | input | 1 | HS output polarity, 1 = active high |
| cfg_fid_pos | input | 1 | Field output polarity, 1 = active high |
| hs_in | input | 1 | Dedicated horizontal sync, active high |
| vs_in | input | 1 | Dedicated vertical sync, active high |
| fid_de_in | input | 1 | Multipurpose field / data-enable pin |
| pix_y_g | input | 10 | Channel 0 pixel input (Y or G) |
| pix_pb_b | input | 10 | Channel 1 pixel input (Pb or B) |
| pix_pr_r | input | 10 | Channel 2 pixel input (Pr or R) |
| out_y_g | output | 10 | Channel 0 pixel output |
| out_pb_b | output | 10 | Channel 1 pixel output |
| out_pr_r | output | 10 | Channel 2 pixel output |
| hs_out | output | 1 | Horizontal sync output |
| vs_out | output | 1 | Vertical sync output |
| fid_out | output | 1 | Field output |
| line_total_hi | output | 3 | Upper bits of the stored line total |
| line_total_lo | output | 8 | Lower bits of the stored line total |

## Verification
An HS rise and a frame start can fall in the same clock. That cycle drives both the line counter, which must restart at one and not add the pulse to the stored total, and the field state machine, which must see the VS edge as aligned with the line start. The bench provokes this by starting a VS pulse on the same clock as an HS pulse. It then checks that the stored total leaves out that line while the next total includes it. It also checks that, in derived mode, the recovered field is 0 while the ignored pin is held at 1.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

    typedef enum logic [1:0] {
        PM_FIELD_PIN,
        PM_DATA_EN,
        PM_FIELD_DERIVED,
        PM_EMBEDDED
    } pin_mode_e;

    typedef enum logic [1:0] {
        FD_NO_SYNC,
        FD_MEASURE,
        FD_LOCKED
    } fd_state_e;

    function automatic pin_mode_e decode_mode(input logic embedded,
                                              input logic pin_is_de,
                                              input logic pc_graphics);
        if (embedded)
            return PM_EMBEDDED;
        else if (!pin_is_de)
            return PM_FIELD_PIN;
        else if (pc_graphics)
            return PM_DATA_EN;
        else
            return PM_FIELD_DERIVED;
    endfunction

endpackage

// File: rtl/vtf_field_fsm.sv
module vtf_field_fsm
    import vtf_pkg::*;
#(
    parameter int HPOS_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_rise,
    input  logic vs_rise,
    output logic field_id
);
    localparam logic [HPOS_W-1:0] HPOS_MAX = {HPOS_W{1'b1}};
    localparam int WIDE_W = HPOS_W + 2;

    fd_state_e         state_q, state_nx;
    logic [HPOS_W-1:0] hpos_q;
    logic [HPOS_W-1:0] hper_q;
    logic [WIDE_W-1:0] pos_x4, per_x1, per_x3;
    logic              in_window;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FD_NO_SYNC;
        else
            state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FD_NO_SYNC: if (hs_rise) state_nx = FD_MEASURE;
            FD_MEASURE: begin
                if (hs_rise)                 state_nx = FD_LOCKED;
                else if (hpos_q == HPOS_MAX) state_nx = FD_NO_SYNC;
            end
            FD_LOCKED:  if (!hs_rise && hpos_q == HPOS_MAX) state_nx = FD_NO_SYNC;
            default:    state_nx = FD_NO_SYNC;
        endcase
    end

    // line position and period measurement
    always_ff @(posedge clk) begin
        if (rst) begin
            hpos_q <= '0;
            hper_q <= '0;
        end else if (hs_rise) begin
            hper_q <= (hpos_q == HPOS_MAX) ? HPOS_MAX : hpos_q + 1'b1;
            hpos_q <= '0;
        end else if (hpos_q != HPOS_MAX) begin
            hpos_q <= hpos_q + 1'b1;
        end
    end

    assign pos_x4    = {hpos_q, 2'b00};
    assign per_x1    = {2'b00, hper_q};
    assign per_x3    = {1'b0, hper_q, 1'b0} + {2'b00, hper_q};
    assign in_window = (pos_x4 >= per_x1) && (pos_x4 <= per_x3);

    // field output register
    always_ff @(posedge clk) begin
        if (rst)
            field_id <= 1'b0;
        else if (vs_rise && state_q == FD_LOCKED)
            field_id <= in_window;
    end

    // R5
    locked_has_period_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == FD_LOCKED) |-> (hper_q != '0));

    // R5
    field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vs_rise |=> $stable(field_id));

    // R7
    aligned_field_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vs_rise && hs_rise && state_q == FD_LOCKED && hper_q > 4) |=> !field_id);

endmodule

// File: rtl/vtf_line_counter.sv
module vtf_line_counter #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_rise,
    input  logic              frame_start,
    output logic [LINE_W-1:0] total_o
);
    localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            total_o <= '0;
        end else if (frame_start) begin
            total_o <= run_q;
            run_q   <= hs_rise ? LINE_W'(1) : '0;
        end else if (hs_rise && run_q != CNT_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R8
    count_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> (run_q >= $past(run_q)));

    // R7
    restart_small_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (run_q <= LINE_W'(1)));

    // R6
    total_only_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(total_o));

endmodule

// File: rtl/vtf_out_stage.sv
module vtf_out_stage #(
    parameter int PIX_W = 10,
    parameter int N_CH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_i   [N_CH],
    input  logic [PIX_W-1:0] blank_i [N_CH],
    input  logic             gate_blank,
    input  logic             hs_lvl,
    input  logic             vs_lvl,
    input  logic             fid_lvl,
    input  logic             hs_pos,
    input  logic             vs_neg,
    input  logic             fid_pos,
    output logic [PIX_W-1:0] pix_o   [N_CH],
    output logic             hs_o,
    output logic             vs_o,
    output logic             fid_o
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst || gate_blank)
                pix_o[ch] <= blank_i[ch];
            else
                pix_o[ch] <= pix_i[ch];
        end

        // R3
        blank_when_gated_chk: assert property (@(posedge clk) disable iff (rst)
            gate_blank |=> (pix_o[ch] == $past(blank_i[ch])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_o  <= ~hs_pos;
            vs_o  <= vs_neg;
            fid_o <= ~fid_pos;
        end else begin
            hs_o  <= hs_lvl  ^ ~hs_pos;
            vs_o  <= vs_lvl  ^ vs_neg;
            fid_o <= fid_lvl ^ ~fid_pos;
        end
    end

endmodule

// File: rtl/vid_timing_front.sv
module vid_timing_front
    import vtf_pkg::*;
#(
    parameter int PIX_W     = 10,
    parameter int LINE_W    = 11,
    parameter int HPOS_W    = 12,
    parameter int BLANK_LOW = 64,
    parameter int BLANK_MID = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_pin_is_de,
    input  logic              cfg_pc_graphics,
    input  logic              cfg_rgb_space,
    input  logic              cfg_sync_embedded,
    input  logic              cfg_vs_neg,
    input  logic              cfg_hs_pos,
    input  logic              cfg_fid_pos,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              fid_de_in,
    input  logic [PIX_W-1:0]  pix_y_g,
    input  logic [PIX_W-1:0]  pix_pb_b,
    input  logic [PIX_W-1:0]  pix_pr_r,
    output logic [PIX_W-1:0]  out_y_g,
    output logic [PIX_W-1:0]  out_pb_b,
    output logic [PIX_W-1:0]  out_pr_r,
    output logic              hs_out,
    output logic              vs_out,
    output logic              fid_out,
    output logic [LINE_W-9:0] line_total_hi,
    output logic [7:0]        line_total_lo
);
    localparam int N_CH = 3;
    localparam logic [PIX_W-1:0] CODE_LOW = PIX_W'(BLANK_LOW);
    localparam logic [PIX_W-1:0] CODE_MID = PIX_W'(BLANK_MID);

    pin_mode_e         mode;
    logic              hs_int, vs_int, pin_int;
    logic              hs_q, vs_q;
    logic              hs_rise, vs_rise;
    logic              derived_fid;
    logic              fid_lvl;
    logic              gate_blank;
    logic [LINE_W-1:0] total;
    logic [PIX_W-1:0]  pix_arr   [N_CH];
    logic [PIX_W-1:0]  blank_arr [N_CH];
    logic [PIX_W-1:0]  out_arr   [N_CH];

    assign mode    = decode_mode(cfg_sync_embedded, cfg_pin_is_de, cfg_pc_graphics);
    assign hs_int  = hs_in     & (mode != PM_EMBEDDED);
    assign vs_int  = vs_in     & (mode != PM_EMBEDDED);
    assign pin_int = fid_de_in & (mode != PM_EMBEDDED);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hs_int;
            vs_q <= vs_int;
        end
    end

    assign hs_rise = hs_int & ~hs_q;
    assign vs_rise = vs_int & ~vs_q;

    // field and gating selection per mode
    always_comb begin
        fid_lvl    = 1'b0;
        gate_blank = 1'b0;
        unique case (mode)
            PM_FIELD_PIN:     fid_lvl = pin_int;
            PM_DATA_EN:       gate_blank = ~pin_int;
            PM_FIELD_DERIVED: fid_lvl = derived_fid;
            PM_EMBEDDED:      fid_lvl = 1'b0;
            default:          fid_lvl = 1'b0;
        endcase
    end

    assign blank_arr[0] = CODE_LOW;
    assign blank_arr[1] = cfg_rgb_space ? CODE_LOW : CODE_MID;
    assign blank_arr[2] = cfg_rgb_space ? CODE_LOW : CODE_MID;

    assign pix_arr[0] = pix_y_g;
    assign pix_arr[1] = pix_pb_b;
    assign pix_arr[2] = pix_pr_r;

    vtf_field_fsm #(.HPOS_W(HPOS_W)) u_field (
        .clk      (clk),
        .rst      (rst),
        .hs_rise  (hs_rise),
        .vs_rise  (vs_rise),
        .field_id (derived_fid)
    );

    vtf_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk         (clk),
        .rst         (rst),
        .hs_rise     (hs_rise),
        .frame_start (vs_rise),
        .total_o     (total)
    );

    vtf_out_stage #(.PIX_W(PIX_W), .N_CH(N_CH)) u_out (
        .clk        (clk),
        .rst        (rst),
        .pix_i      (pix_arr),
        .blank_i    (blank_arr),
        .gate_blank (gate_blank),
        .hs_lvl     (hs_int),
        .vs_lvl     (vs_int),
        .fid_lvl    (fid_lvl),
        .hs_pos     (cfg_hs_pos),
        .vs_neg     (cfg_vs_neg),
        .fid_pos    (cfg_fid_pos),
        .pix_o      (out_arr),
        .hs_o       (hs_out),
        .vs_o       (vs_out),
        .fid_o      (fid_out)
    );

    assign out_y_g       = out_arr[0];
    assign out_pb_b      = out_arr[1];
    assign out_pr_r      = out_arr[2];
    assign line_total_hi = total[LINE_W-1:8];
    assign line_total_lo = total[7:0];

    // R10
    embedded_sync_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_sync_embedded |=> (hs_out == !$past(cfg_hs_pos)) && (vs_out == $past(cfg_vs_neg)));

    // R10
    embedded_total_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_sync_embedded |=> ({line_total_hi, line_total_lo} == $past({line_total_hi, line_total_lo})));

    // R2
    pin_field_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sync_embedded && !cfg_pin_is_de) |=> (fid_out == ($past(fid_de_in) ~^ $past(cfg_fid_pos))));

    // R4
    ycc_luma_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DATA_EN && !fid_de_in) |=> (out_y_g == CODE_LOW));

endmodule

// File: tb/vid_timing_front_tb.sv
`timescale 1ns/1ps
module vid_timing_front_tb;

    typedef struct {
        logic [9:0] p0, p1, p2;
        logic       hs, vs, fid, fid_chk;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_pin_is_de = 0, cfg_pc_graphics = 0, cfg_rgb_space = 1, cfg_sync_embedded = 0;
    logic cfg_vs_neg = 1, cfg_hs_pos = 1, cfg_fid_pos = 1;
    logic s_de = 0, s_pc = 0, s_rgb = 1, s_emb = 0, s_vsn = 1, s_hsp = 1, s_fidp = 1;
    logic hs_in = 0, vs_in = 0, fid_de_in = 0;
    logic [9:0] pix_y_g = 0, pix_pb_b = 0, pix_pr_r = 0;
    logic [9:0] out_y_g, out_pb_b, out_pr_r;
    logic hs_out, vs_out, fid_out;
    logic [2:0] line_total_hi;
    logic [7:0] line_total_lo;

    int total = 0;
    int bad = 0;
    bit sb_on = 0;
    exp_t sbq[$];

    always #10 clk = ~clk;

    vid_timing_front u_dut (
        .clk(clk), .rst(rst),
        .cfg_pin_is_de(cfg_pin_is_de), .cfg_pc_graphics(cfg_pc_graphics),
        .cfg_rgb_space(cfg_rgb_space), .cfg_sync_embedded(cfg_sync_embedded),
        .cfg_vs_neg(cfg_vs_neg), .cfg_hs_pos(cfg_hs_pos), .cfg_fid_pos(cfg_fid_pos),
        .hs_in(hs_in), .vs_in(vs_in), .fid_de_in(fid_de_in),
        .pix_y_g(pix_y_g), .pix_pb_b(pix_pb_b), .pix_pr_r(pix_pr_r),
        .out_y_g(out_y_g), .out_pb_b(out_pb_b), .out_pr_r(out_pr_r),
        .hs_out(hs_out), .vs_out(vs_out), .fid_out(fid_out),
        .line_total_hi(line_total_hi), .line_total_lo(line_total_lo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] blank_code(input int ch, input logic rgb);
        // R4: 64 everywhere in RGB; 512 on colour-difference channels otherwise
        if (ch == 0 || rgb) return 10'd64;
        return 10'd512;
    endfunction

    // driver: one cycle of stimulus, pushes the expected outputs
    task automatic cyc(input logic h, input logic v, input logic p);
        exp_t e;
        logic hs_e, vs_e, f_e, de_gate;
        @(negedge clk);
        cfg_pin_is_de = s_de; cfg_pc_graphics = s_pc; cfg_rgb_space = s_rgb;
        cfg_sync_embedded = s_emb; cfg_vs_neg = s_vsn; cfg_hs_pos = s_hsp; cfg_fid_pos = s_fidp;
        hs_in = h; vs_in = v; fid_de_in = p;
        pix_y_g = 10'($urandom); pix_pb_b = 10'($urandom); pix_pr_r = 10'($urandom);
        if (sb_on) begin
            hs_e = s_emb ? 1'b0 : h;
            vs_e = s_emb ? 1'b0 : v;
            de_gate = !s_emb && s_de && s_pc && !p;
            e.fid_chk = 1'b1;
            if (s_emb || (s_de && s_pc)) f_e = 1'b0;
            else if (!s_de) f_e = p;
            else begin f_e = 1'b0; e.fid_chk = 1'b0; end
            e.p0 = de_gate ? blank_code(0, s_rgb) : pix_y_g;
            e.p1 = de_gate ? blank_code(1, s_rgb) : pix_pb_b;
            e.p2 = de_gate ? blank_code(2, s_rgb) : pix_pr_r;
            e.hs = s_hsp ? hs_e : ~hs_e;
            e.vs = s_vsn ? ~vs_e : vs_e;
            e.fid = s_fidp ? f_e : ~f_e;
            sbq.push_back(e);
        end
    endtask

    // monitor: compares one clock after each driven cycle (R11)
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_on && sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk("R11/R3 ch0", out_y_g, e.p0);
                chk("R11/R3 ch1", out_pb_b, e.p1);
                chk("R11/R3 ch2", out_pr_r, e.p2);
                chk("R9/R10 hs_out", hs_out, e.hs);
                chk("R9/R10 vs_out", vs_out, e.vs);
                if (e.fid_chk) chk("R2/R9 fid_out", fid_out, e.fid);
            end
        end
    end

    // lines of 40 clocks, HS high 4 clocks; VS pulse in the last line from vs_at
    task automatic run_lines(input int n, input int vs_at, input logic pin);
        for (int l = 0; l < n; l++)
            for (int c = 0; c < 40; c++)
                cyc(c < 4, (l == n - 1) && c >= vs_at && c < vs_at + 8, pin);
    endtask

    task automatic idle(input int n, input logic pin);
        for (int i = 0; i < n; i++) cyc(0, 0, pin);
    endtask

    function automatic logic [10:0] rd_total();
        return {line_total_hi, line_total_lo};
    endfunction

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [10:0] frozen;
        repeat (3) @(negedge clk);
        @(posedge clk); #5;
        // R1 reset state, RGB default
        chk("R1 ch0", out_y_g, 64);
        chk("R1 ch1", out_pb_b, 64);
        chk("R1 ch2", out_pr_r, 64);
        chk("R1 hs_out", hs_out, 0);
        chk("R1 vs_out", vs_out, 1);
        chk("R1 fid_out", fid_out, 0);
        chk("R1 total", rd_total(), 0);
        @(negedge clk);
        rst = 1'b0;
        sb_on = 1;

        // R2 field pin mode, toggling pin
        for (int i = 0; i < 20; i++) cyc(i[0], 0, i[1]);

        // R6 line counting between frame starts
        run_lines(3, 20, 0);
        run_lines(5, 20, 1);
        idle(2, 0);
        chk("R6 total lo", line_total_lo, 5);
        chk("R6 total hi", line_total_hi, 0);

        // R7 HS rise coincident with frame start
        run_lines(7, 0, 0);
        idle(2, 0);
        chk("R7 total excludes coincident", rd_total(), 6);
        run_lines(2, 20, 0);
        idle(2, 0);
        chk("R7 coincident in next frame", rd_total(), 3);

        // R9 polarity inversions
        s_hsp = 0; s_vsn = 0; s_fidp = 0;
        run_lines(2, 10, 1);
        for (int i = 0; i < 10; i++) cyc(0, 0, i[0]);
        s_hsp = 1; s_vsn = 1; s_fidp = 1;

        // R5 derived field, pin ignored
        s_de = 1; s_pc = 0;
        run_lines(4, 20, 0);
        idle(3, 0);
        chk("R5 mid-line vs gives field 1", fid_out, 1);
        run_lines(4, 0, 1);
        idle(3, 1);
        chk("R7 aligned vs gives field 0", fid_out, 0);
        run_lines(3, 25, 0);
        idle(3, 0);
        chk("R5 field 1 again", fid_out, 1);

        // R3 data-enable gating, RGB then YPbPr (R4)
        s_pc = 1;
        for (int i = 0; i < 30; i++) cyc(0, 0, i[1] ^ i[2]);
        s_rgb = 0;
        for (int i = 0; i < 30; i++) cyc(i == 3, 0, i[0] | i[3]);
        cyc(0, 0, 0);
        @(posedge clk); #5;
        chk("R4 ycc pb blank", out_pb_b, 512);
        chk("R4 ycc y blank", out_y_g, 64);
        s_rgb = 1; s_de = 0; s_pc = 0;

        // R8 saturation
        run_lines(1, 20, 0);
        for (int i = 0; i < 2100; i++) begin cyc(1, 0, 0); cyc(0, 0, 0); end
        cyc(0, 1, 0);
        idle(2, 0);
        chk("R8 saturated total", rd_total(), 2047);
        chk("R8 hi part", line_total_hi, 7);

        // R10 embedded: dedicated inputs ignored
        frozen = rd_total();
        s_emb = 1;
        run_lines(3, 20, 1);
        run_lines(4, 20, 0);
        idle(2, 1);
        chk("R10 total frozen", rd_total(), frozen);
        s_emb = 0;
        idle(4, 0);

        sb_on = 0;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule